// File: doc/BRIEF.md
# Windowed Packet Serializer with CRC Trailer

This block puts one packet per sending window onto a single serial line that rests at logic 1. Such a line could drive an optical link between the layers of a distributed converter controller. A packet holds a fixed number of data frames, set at build time, and ends with one check frame. Each frame has eleven bits: a low start bit, eight payload bits sent least significant first, an even-parity bit and a high stop bit. The check frame carries a CRC-8 over every data byte of the packet in place of data.

The bit rate comes from a one-clock `baud_tick` enable: each bit lasts one tick period. A window timer counts ticks. It opens a new window every `window_len` ticks. At the opening it copies the parallel data bytes into a shadow store and starts a packet. After the last stop bit the line stays high until the next window opens. If a window opens while a packet is still going out, that packet runs to its end, no new packet starts in that window, and `overrun` pulses for one clock.

Top module: `pst_packet_tx`

## Requirements
- R1: While no packet is being sent, including during reset, `tx_line` is 1 and `busy` is 0.
- R2: Every frame is 11 bit periods long: a start bit of 0, then payload bits 0 to 7 in ascending order, then a parity bit, then a stop bit of 1.
- R3: The parity bit makes the count of ones across the eight payload bits and the parity bit even.
- R4: A packet sends data byte i, taken from `data_in[8*i+7:8*i]`, in frame i for i = 0 to NUM_BYTES-1. One check frame follows, so the packet has NUM_BYTES+1 frames.
- R5: The check frame payload is a CRC-8 with polynomial 0x07 (x^8+x^2+x+1) and initial value 0x00. It is shifted most significant bit first over the data bytes in frame order, with no final inversion.
- R6: A window opens on the first `baud_tick` after reset and again every `window_len` ticks. A packet starts at each window opening that finds the block free, so packet starts are `window_len` ticks apart when a packet fits in the window.
- R7: The data bytes are captured at the window opening. Later changes to `data_in` do not alter the packet in flight.
- R8: A window opening that falls while a packet is still in progress, other than on its final tick, does not disturb that packet, starts no packet, and raises `overrun` for exactly one clock.
- R9: `tx_line` changes only in the clock after a `baud_tick`, so each bit lasts one tick period.
- R10: When `window_len` equals 11*(NUM_BYTES+1), packets follow back to back with no idle bit and no overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-clock enable, one pulse per bit period |
| window_len | input | WIN_W | Sending window length in baud ticks (0 is treated as 1) |
| data_in | input | 8*NUM_BYTES | Data bytes, byte i in bits 8i+7 down to 8i |
| tx_line | output | 1 | Serial line, high when idle |
| busy | output | 1 | A packet is being sent |
| overrun | output | 1 | One-clock pulse when a window opens on a packet still in flight |

## Verification
The assertions check on every cycle the properties that the ports alone settle. The line is high whenever the block is not busy, and a packet opens with a low start bit. Line changes, packet starts and overrun pulses all follow a baud tick, and an overrun only appears while a packet is still running. The bench scenarios are the only place to show the properties that need a whole frame or packet decoded. These are the bit order, the parity and CRC values, and the capture of the data bytes at the window opening in spite of later input changes. They also cover the spacing of packet starts for roomy, exactly fitting and too-short windows.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int FRAME_BITS = 11;
  localparam int BIT_IDX_W  = 4;
  localparam logic [7:0] CRC_POLY = 8'h07;
  typedef logic [BIT_IDX_W-1:0] bit_idx_t;
endpackage

// File: rtl/pst_window_timer.sv
module pst_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [WIN_W-1:0] len,
  output logic             win_start
);
  logic [WIN_W-1:0] cnt_q, cnt_d;
  logic [WIN_W-1:0] reload;

  assign reload    = (len == '0) ? '0 : len - 1'b1;
  assign win_start = tick && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      if (cnt_q == '0) cnt_d = reload;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pst_crc8.sv
module pst_crc8 #(
  parameter int NUM_BYTES = 14
) (
  input  logic [8*NUM_BYTES-1:0] bytes,
  output logic [7:0]             crc
);
  import pst_pkg::*;

  always_comb begin
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < NUM_BYTES; i++) begin
      acc = acc ^ bytes[8*i +: 8];
      for (int b = 0; b < 8; b++) begin
        if (acc[7]) acc = {acc[6:0], 1'b0} ^ CRC_POLY;
        else        acc = {acc[6:0], 1'b0};
      end
    end
    crc = acc;
  end
endmodule

// File: rtl/pst_frame_fmt.sv
module pst_frame_fmt (
  input  logic [7:0]                     payload,
  output logic [pst_pkg::FRAME_BITS-1:0] frame
);
  // index 0 goes out first
  assign frame = {1'b1, ^payload, payload, 1'b0};
endmodule

// File: rtl/pst_packet_tx.sv
module pst_packet_tx #(
  parameter int NUM_BYTES = 14,
  parameter int WIN_W     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   baud_tick,
  input  logic [WIN_W-1:0]       window_len,
  input  logic [8*NUM_BYTES-1:0] data_in,
  output logic                   tx_line,
  output logic                   busy,
  output logic                   overrun
);
  import pst_pkg::*;

  localparam int FIDX_W = $clog2(NUM_BYTES + 1);
  localparam logic [FIDX_W-1:0] LAST_FRAME = FIDX_W'(NUM_BYTES);
  localparam bit_idx_t LAST_BIT = bit_idx_t'(FRAME_BITS - 1);

  logic [8*NUM_BYTES-1:0] shadow_q, shadow_d;
  logic [FIDX_W-1:0]      frame_q, frame_d;
  bit_idx_t               bit_q, bit_d;
  logic                   busy_q, busy_d;
  logic                   tx_q, tx_d;
  logic                   ovr_q, ovr_d;

  logic                   win_start;
  logic                   last_tick;
  logic                   launch;
  logic [7:0]             crc_val;
  logic [7:0]             cur_byte;
  logic [FRAME_BITS-1:0]  cur_frame;

  pst_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (baud_tick),
    .len      (window_len),
    .win_start(win_start)
  );

  pst_crc8 #(.NUM_BYTES(NUM_BYTES)) u_crc (
    .bytes(shadow_q),
    .crc  (crc_val)
  );

  pst_frame_fmt u_fmt (
    .payload(cur_byte),
    .frame  (cur_frame)
  );

  always_comb begin
    cur_byte = crc_val;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (frame_q == FIDX_W'(i)) cur_byte = shadow_q[8*i +: 8];
    end
  end

  assign last_tick = busy_q && baud_tick && (bit_q == LAST_BIT) && (frame_q == LAST_FRAME);
  assign launch    = win_start && (!busy_q || last_tick);

  always_comb begin
    shadow_d = shadow_q;
    frame_d  = frame_q;
    bit_d    = bit_q;
    busy_d   = busy_q;
    tx_d     = tx_q;
    ovr_d    = win_start && busy_q && !last_tick;
    if (baud_tick && busy_q) begin
      if (bit_q != LAST_BIT) begin
        bit_d = bit_q + 1'b1;
        tx_d  = cur_frame[bit_q + 1'b1];
      end else if (frame_q != LAST_FRAME) begin
        frame_d = frame_q + 1'b1;
        bit_d   = '0;
        tx_d    = 1'b0;
      end else begin
        busy_d = 1'b0;
        tx_d   = 1'b1;
      end
    end
    if (launch) begin
      shadow_d = data_in;
      frame_d  = '0;
      bit_d    = '0;
      busy_d   = 1'b1;
      tx_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      frame_q  <= '0;
      bit_q    <= '0;
      busy_q   <= 1'b0;
      tx_q     <= 1'b1;
      ovr_q    <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      frame_q  <= frame_d;
      bit_q    <= bit_d;
      busy_q   <= busy_d;
      tx_q     <= tx_d;
      ovr_q    <= ovr_d;
    end
  end

  assign tx_line = tx_q;
  assign busy    = busy_q;
  assign overrun = ovr_q;
endmodule

// File: rtl/pst_packet_tx_chk.sv
module pst_packet_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic baud_tick,
  input logic tx_line,
  input logic busy,
  input logic overrun
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_line);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tx_line);

  a_r9_line_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tx_line) |-> $past(baud_tick));

  a_r6_launch_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(baud_tick));

  a_r8_overrun_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> busy && $past(busy));

  a_r8_overrun_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(baud_tick));

  a_r8_overrun_single: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> !overrun);
endmodule

bind pst_packet_tx pst_packet_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .baud_tick(baud_tick),
  .tx_line  (tx_line),
  .busy     (busy),
  .overrun  (overrun)
);

// File: tb/sim_pst_packet_tx.sv
`timescale 1ns/1ps
module sim_pst_packet_tx;
  localparam int NB        = 3;
  localparam int WW        = 16;
  localparam int TDIV      = 4;
  localparam int PKT_TICKS = 11 * (NB + 1);
  localparam int NPKT      = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          baud_tick;
  logic [WW-1:0] window_len;
  logic [8*NB-1:0] data_in;
  logic          tx_line, busy, overrun;

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int gap_q[$];
  int ov_cnt = 0;
  int pkt_seen = 0;
  int tc = 0;
  int wsched [NPKT];

  always #2.5 clk = ~clk;

  pst_packet_tx #(.NUM_BYTES(NB), .WIN_W(WW)) u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .window_len(window_len),
    .data_in(data_in), .tx_line(tx_line), .busy(busy), .overrun(overrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_ref(input logic [8*NB-1:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < NB; i++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[7] ^ d[8*i + b];
        c = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
      end
    return c;
  endfunction

  function automatic logic [8*NB-1:0] pattern(input int k);
    logic [8*NB-1:0] p;
    for (int i = 0; i < NB; i++) begin
      case (k)
        1:       p[8*i +: 8] = 8'h00;
        2:       p[8*i +: 8] = 8'hFF;
        3:       p[8*i +: 8] = (i % 2 == 0) ? 8'hAA : 8'h55;
        default: p[8*i +: 8] = 8'((k * 37 + i * 91 + 13) ^ (k << 3));
      endcase
    end
    return p;
  endfunction

  task automatic push_pkt(input logic [8*NB-1:0] d, input int gap);
    gap_q.push_back(gap);
    for (int i = 0; i < NB; i++)
      exp_q.push_back({23'd0, (i == 0), d[8*i +: 8]});
    exp_q.push_back({24'd0, crc_ref(d)});
  endtask

  // baud tick, one clock in TDIV
  always @(negedge clk) begin
    if (!rst_n) begin
      tc = 0;
      baud_tick <= 1'b0;
    end else begin
      baud_tick <= (tc == TDIV - 1);
      tc = (tc + 1) % TDIV;
    end
  end

  always @(negedge clk) if (rst_n === 1'b1 && overrun === 1'b1) ov_cnt++;

  // monitor: decodes frames and compares with the scoreboard
  initial begin
    realtime tprev = -1.0;
    wait (rst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (tx_line === 1'b0) begin
        realtime t;
        int item, g;
        logic [10:0] bits;
        t = $realtime;
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected frame", 1, 0);
          item = 0;
        end else item = exp_q.pop_front();
        if (item[8]) begin
          pkt_seen++;
          g = gap_q.pop_front();
          if (tprev >= 0 && g != 0)
            check(int'((t - tprev) / 5.0) == g * TDIV,
                  (g == PKT_TICKS) ? "R10 start spacing" : "R6 start spacing",
                  int'((t - tprev) / 5.0), g * TDIV);
          tprev = t;
        end
        repeat (2) @(negedge clk);
        bits[0] = tx_line;
        for (int b = 1; b < 11; b++) begin
          repeat (TDIV) @(negedge clk);
          bits[b] = tx_line;
        end
        check(bits[0] == 1'b0, "R2 start bit", bits[0], 0);
        check(bits[8:1] == item[7:0], "R4/R5 payload", bits[8:1], item[7:0]); // R4 R5
        check(bits[9] == ^item[7:0], "R3 parity", bits[9], ^item[7:0]);
        check(bits[10] == 1'b1, "R2 stop bit", bits[10], 1);
      end
    end
  end

  // driver
  initial begin
    for (int k = 0; k < NPKT; k++)
      wsched[k] = (k < 4) ? 50 : (k < 7) ? PKT_TICKS : (k < 10) ? 20 : 50;
    rst_n = 1'b0;
    window_len = WW'(wsched[0]);
    data_in = pattern(0);
    push_pkt(pattern(0), 0);
    repeat (3) @(negedge clk);
    check(tx_line === 1'b1, "R1 reset line", tx_line, 1);
    check(busy === 1'b0, "R1 reset busy", busy, 0);
    check(overrun === 1'b0, "R8 reset overrun", overrun, 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < NPKT - 1; k++) begin
      int w, g;
      wait (pkt_seen == k + 1);
      if (k == 6) check(ov_cnt == 0, "R10 no overrun when packet fits", ov_cnt, 0);
      // R7: inputs change right after capture, packet k must be unaffected
      data_in = pattern(k + 1);
      window_len = WW'(wsched[k + 1]);
      w = wsched[k];
      if (w >= PKT_TICKS) g = w;
      else if (wsched[k] == wsched[k + 1]) g = ((PKT_TICKS + w - 1) / w) * w;
      else g = 0;
      push_pkt(pattern(k + 1), g);
    end
    wait (pkt_seen == NPKT);
    wait (exp_q.size() == 0);
    wait (busy === 1'b0);
    repeat (4) @(negedge clk);
    check(tx_line === 1'b1, "R1 idle after last packet", tx_line, 1);
    check(ov_cnt > 0, "R8 overrun reported", ov_cnt, 1);
    check(exp_q.size() == 0, "R4 all frames seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", pkt_seen, NPKT);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule